// File: doc/BRIEF.md
# T1 ESF Bit-Oriented Message Receiver

This block watches the 4 kbit/s data link of a T1 Extended Superframe, one bit per strobe, and decides on its own whether the link is carrying HDLC frames or bit-oriented messages. It comes out of reset in HDLC mode. A run of eight ones moves it to message mode, and a flag octet moves it back. In message mode, each run of eight ones fixes the byte boundary. The eight bits that follow the run are collected and passed to a receive FIFO, but only if the first and the last of those bits are zero.

A watchdog raises a one-cycle interrupt when 32 message-mode bits go by without an eight-ones window. Byte sampling carries on after the interrupt. Each valid bit is also handed to an external HDLC receiver whenever that receiver is enabled, in both modes. This lets a frame that arrives during message mode be taken at once, with no leading flags.

Top module: `bomRx`

## Requirements
- R1: After reset, `bomMode`, `wrValid` and `syncLossIrq` are all 0, so the block starts in HDLC mode.
- R2: While `bomEn` is 0, `bomMode` stays 0 and no write or interrupt is produced, whatever bits arrive.
- R3: With `bomEn` set and `bomMode` at 0, the valid bit that completes eight consecutive ones sets `bomMode`. The new value is visible after that bit's clock edge.
- R4: In message mode with `hdlcEn` set, a window of the last eight valid bits equal to 0,1,1,1,1,1,1,0 clears `bomMode`. With `hdlcEn` at 0, the flag has no effect on the mode.
- R5: In message mode, the eight valid bits that directly follow an eight-ones window form a byte. `wrData` bit 0 is the first of these bits and bit 7 is the last. A qualified byte gives a one-cycle `wrValid` pulse after the edge of its last bit.
- R6: A byte is written only when its first and its last bit are both 0. Bytes with 1 at either end are dropped.
- R7: Once a byte completes, the next byte needs a fresh eight-ones window. This window may be the byte itself, so a continuous ones stream realigns every eight bits.
- R8: In message mode, the 32nd consecutive valid bit that ends no eight-ones window raises `syncLossIrq` for one cycle. The count then restarts, and neither the mode nor byte sampling is affected.
- R9: `hdlcValid` equals `dlValid` AND `hdlcEn` in either mode.
- R10: Cycles with `dlValid` at 0 change neither the mode, the alignment nor the byte being collected.
- R11: A message byte equal to the flag pattern (0x7E) is written and also returns the block to HDLC mode, when `hdlcEn` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dlBit | input | 1 | Data link bit |
| dlValid | input | 1 | Strobe marking `dlBit` valid |
| hdlcEn | input | 1 | HDLC receiver enable |
| bomEn | input | 1 | Message receiver enable |
| bomMode | output | 1 | 1 = message mode, 0 = HDLC mode |
| hdlcValid | output | 1 | Bit strobe for the external HDLC receiver |
| wrData | output | 8 | Message byte for the receive FIFO |
| wrValid | output | 1 | FIFO write pulse |
| syncLossIrq | output | 1 | Sync-loss interrupt pulse |

## Verification
`hdlcValid` is combinational, so it is checked one nanosecond after each bit is driven. The other outputs (mode, write pulse with its data, and interrupt) are registered. They change on the clock edge that takes the bit, and are compared at the falling edge that follows. The bench drives inputs at falling edges, advances a behavioural model by that bit, and compares the model's prediction against every output at the next falling edge. This includes cycles with no valid bit, which must leave all outputs unchanged. Scenario checks then confirm the captured byte values and the interrupt count over a long window.

// File: rtl/bomRxPkg.sv
package bomRxPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic winShift;   // advance the eight-bit history window
    logic byteShift;  // advance the message byte being collected
    logic byteStore;  // latch the completed byte into the output register
  } dpStrobe_t;
endpackage

// File: rtl/bomRxDatapath.sv
module bomRxDatapath
  import bomRxPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dlBit,
  input  dpStrobe_t         strobe,
  output logic              winAllOnes,
  output logic              winFlag,
  output logic              byteOk,
  output logic [BYTE_W-1:0] wrData
);
  localparam logic [BYTE_W-1:0] FLAG = {1'b0, {(BYTE_W-2){1'b1}}, 1'b0};

  logic [BYTE_W-2:0] win;
  logic [BYTE_W-1:0] winNext;
  logic [BYTE_W-2:0] byteSr;
  logic [BYTE_W-1:0] byteNext;

  // window: oldest bit at the top, incoming bit at bit 0
  assign winNext    = {win, dlBit};
  assign winAllOnes = &winNext;
  assign winFlag    = (winNext == FLAG);

  // byte: incoming bit enters at the top, so the first bit ends at bit 0
  assign byteNext = {dlBit, byteSr};
  assign byteOk   = !byteNext[0] && !byteNext[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win    <= '0;
      byteSr <= '0;
      wrData <= '0;
    end else begin
      if (strobe.winShift)  win    <= winNext[BYTE_W-2:0];
      if (strobe.byteShift) byteSr <= byteNext[BYTE_W-1:1];
      if (strobe.byteStore) wrData <= byteNext;
    end
  end
endmodule

// File: rtl/bomRxControl.sv
module bomRxControl
  import bomRxPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int WD_BITS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      dlValid,
  input  logic      hdlcEn,
  input  logic      bomEn,
  input  logic      winAllOnes,
  input  logic      winFlag,
  input  logic      byteOk,
  output dpStrobe_t strobe,
  output logic      bomMode,
  output logic      wrValid,
  output logic      syncLossIrq
);
  localparam int CNTW = $clog2(BYTE_W);
  localparam int WDW  = $clog2(WD_BITS);
  localparam logic [CNTW-1:0] BIT_LAST = CNTW'(BYTE_W - 1);
  localparam logic [WDW-1:0]  WD_LAST  = WDW'(WD_BITS - 1);

  logic            collecting;
  logic [CNTW-1:0] bitCnt;
  logic [WDW-1:0]  wdCnt;
  logic            entering, activeBom, completing, exitFlag;

  always_comb begin
    entering   = dlValid && bomEn && !bomMode && winAllOnes;
    activeBom  = bomEn && (bomMode || entering);
    completing = dlValid && bomEn && collecting && (bitCnt == BIT_LAST);
    exitFlag   = dlValid && bomEn && bomMode && hdlcEn && winFlag;
    strobe.winShift  = dlValid;
    strobe.byteShift = dlValid && collecting;
    strobe.byteStore = completing && byteOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bomMode     <= 1'b0;
      collecting  <= 1'b0;
      bitCnt      <= '0;
      wdCnt       <= '0;
      wrValid     <= 1'b0;
      syncLossIrq <= 1'b0;
    end else if (!bomEn) begin
      bomMode     <= 1'b0;
      collecting  <= 1'b0;
      bitCnt      <= '0;
      wdCnt       <= '0;
      wrValid     <= 1'b0;
      syncLossIrq <= 1'b0;
    end else begin
      wrValid     <= completing && byteOk;
      syncLossIrq <= 1'b0;
      if (dlValid) begin
        if (entering)      bomMode <= 1'b1;
        else if (exitFlag) bomMode <= 1'b0;

        if (exitFlag || !activeBom) begin
          collecting <= 1'b0;
          bitCnt     <= '0;
        end else if (collecting && !completing) begin
          bitCnt <= bitCnt + 1'b1;
        end else begin
          collecting <= winAllOnes;
          bitCnt     <= '0;
        end

        if (!bomMode || exitFlag || winAllOnes) begin
          wdCnt <= '0;
        end else if (wdCnt == WD_LAST) begin
          wdCnt       <= '0;
          syncLossIrq <= 1'b1;
        end else begin
          wdCnt <= wdCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bomRx.sv
module bomRx
  import bomRxPkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int WD_BITS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dlBit,
  input  logic              dlValid,
  input  logic              hdlcEn,
  input  logic              bomEn,
  output logic              bomMode,
  output logic              hdlcValid,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrValid,
  output logic              syncLossIrq
);
  dpStrobe_t strobe;
  logic winAllOnes, winFlag, byteOk;

  // bits go to the HDLC receiver in both modes
  assign hdlcValid = dlValid && hdlcEn;

  bomRxControl #(.BYTE_W(BYTE_W), .WD_BITS(WD_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .dlValid(dlValid), .hdlcEn(hdlcEn), .bomEn(bomEn),
    .winAllOnes(winAllOnes), .winFlag(winFlag), .byteOk(byteOk),
    .strobe(strobe), .bomMode(bomMode), .wrValid(wrValid), .syncLossIrq(syncLossIrq)
  );

  bomRxDatapath #(.BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .dlBit(dlBit), .strobe(strobe),
    .winAllOnes(winAllOnes), .winFlag(winFlag), .byteOk(byteOk), .wrData(wrData)
  );
endmodule

// File: rtl/bomRxChecker.sv
module bomRxChecker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              dlBit,
  input logic              dlValid,
  input logic              bomEn,
  input logic              bomMode,
  input logic [BYTE_W-1:0] wrData,
  input logic              wrValid,
  input logic              syncLossIrq
);
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !bomEn |=> (!bomMode && !wrValid && !syncLossIrq));

  p_enter_on_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bomMode) |-> $past(dlValid && dlBit && bomEn));

  p_write_after_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(dlValid));

  p_write_qualified_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (!wrData[0] && !wrData[BYTE_W-1]));

  p_irq_in_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    syncLossIrq |-> (bomMode && $past(bomMode)));

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    syncLossIrq |=> !syncLossIrq);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!dlValid && bomEn) |=> ($stable(bomMode) && !wrValid && !syncLossIrq));
endmodule

bind bomRx bomRxChecker #(.BYTE_W(BYTE_W)) uChk (
  .clk(clk), .rstN(rstN), .dlBit(dlBit), .dlValid(dlValid), .bomEn(bomEn),
  .bomMode(bomMode), .wrData(wrData), .wrValid(wrValid), .syncLossIrq(syncLossIrq)
);

// File: tb/bomRx_test.sv
`timescale 1ns/1ps
module bomRx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dlBit = 1'b0, dlValid = 1'b0, hdlcEn = 1'b0, bomEn = 1'b0;
  logic bomMode, hdlcValid, wrValid, syncLossIrq;
  logic [7:0] wrData;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state
  bit hist[$];
  bit byteQ[$];
  bit eMode = 0, eColl = 0, eWr = 0, eIrq = 0;
  int wd = 0;
  logic [7:0] eData = '0;
  logic [7:0] lastWr = '0;
  int wrCount = 0, irqCount = 0;

  always #2 clk = ~clk;

  bomRx uut (
    .clk(clk), .rstN(rstN), .dlBit(dlBit), .dlValid(dlValid), .hdlcEn(hdlcEn),
    .bomEn(bomEn), .bomMode(bomMode), .hdlcValid(hdlcValid), .wrData(wrData),
    .wrValid(wrValid), .syncLossIrq(syncLossIrq)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // behavioural prediction of the outputs after one clock edge
  task automatic modelStep(input bit v, input bit b);
    bit all1, flg, ent, ex, done;
    bit pat[8] = '{0, 1, 1, 1, 1, 1, 1, 0};
    eWr = 0;
    eIrq = 0;
    if (v) begin
      hist.push_back(b);
      if (hist.size() > 8) void'(hist.pop_front());
    end
    if (!bomEn) begin
      eMode = 0; eColl = 0; byteQ.delete(); wd = 0;
      return;
    end
    if (!v) return;
    all1 = (hist.size() == 8);
    flg  = (hist.size() == 8);
    for (int i = 0; i < hist.size(); i++) begin
      if (hist[i] != 1'b1) all1 = 0;
      if (hist.size() == 8 && hist[i] != pat[i]) flg = 0;
    end
    ent  = !eMode && all1;
    ex   = eMode && hdlcEn && flg;
    done = 0;
    if (eColl) begin
      byteQ.push_back(b);
      if (byteQ.size() == 8) begin
        done = 1;
        if (byteQ[0] == 1'b0 && byteQ[7] == 1'b0) begin
          eWr = 1;
          for (int i = 0; i < 8; i++) eData[i] = byteQ[i];
        end
      end
    end
    if (ex || !(eMode || ent)) begin
      eColl = 0; byteQ.delete();
    end else if (!(eColl && !done)) begin
      eColl = all1; byteQ.delete();
    end
    if (!eMode || ex || all1) wd = 0;
    else if (wd == 31) begin wd = 0; eIrq = 1; end
    else wd++;
    if (ent) eMode = 1;
    else if (ex) eMode = 0;
  endtask

  // drive one cycle at a falling edge, compare at the next falling edge
  task automatic sendBit(input bit v, input bit b, input string tag);
    dlValid = v;
    dlBit   = b;
    #1;
    check(hdlcValid == (v && hdlcEn), "R9", "hdlcValid", hdlcValid, v && hdlcEn);
    modelStep(v, b);
    @(negedge clk);
    check(bomMode == eMode, tag, "bomMode", bomMode, eMode);
    check(wrValid == eWr, tag, "wrValid", wrValid, eWr);
    if (eWr) check(wrData == eData, tag, "wrData", wrData, eData);
    check(syncLossIrq == eIrq, tag, "syncLossIrq", syncLossIrq, eIrq);
    if (wrValid) begin lastWr = wrData; wrCount++; end
    if (syncLossIrq) irqCount++;
  endtask

  task automatic sendOnes(input int n, input string tag);
    for (int i = 0; i < n; i++) sendBit(1, 1, tag);
  endtask

  // pat[n-1] is sent first
  task automatic sendSeq(input logic [31:0] pat, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) sendBit(1, pat[i], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL timeout actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int w0, i0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(bomMode == 0 && wrValid == 0 && syncLossIrq == 0, "R1", "reset outputs",
          {bomMode, wrValid, syncLossIrq}, 0);

    // message receiver off
    hdlcEn = 1; bomEn = 0;
    sendOnes(12, "R2");
    check(bomMode == 0, "R2", "mode with bomEn low", bomMode, 0);

    // entry into message mode
    bomEn = 1;
    sendSeq(0, 1, "R3");
    sendOnes(8, "R3");
    check(bomMode == 1, "R3", "mode after eight ones", bomMode, 1);

    // qualified byte, first bit becomes LSB
    sendSeq(8'b01011000, 8, "R5");
    check(lastWr == 8'h1A, "R5", "captured byte", lastWr, 8'h1A);

    // rejected bytes
    w0 = wrCount;
    sendSeq(0, 1, "R6"); sendOnes(8, "R6"); sendSeq(8'b10000001, 8, "R6");
    sendSeq(0, 1, "R6"); sendOnes(8, "R6"); sendSeq(8'b00110001, 8, "R6");
    sendSeq(0, 1, "R6"); sendOnes(8, "R6"); sendSeq(8'b10110100, 8, "R6");
    check(wrCount == w0, "R6", "writes for bad bytes", wrCount - w0, 0);

    // gaps in the strobe
    sendSeq(0, 1, "R10");
    for (int i = 0; i < 8; i++) begin sendBit(1, 1, "R10"); sendBit(0, 0, "R10"); end
    for (int i = 7; i >= 0; i--) begin
      sendBit(1, (8'b01100110 >> i) & 1, "R10");
      sendBit(0, 1, "R10");
    end
    check(lastWr == 8'h66, "R10", "byte across gaps", lastWr, 8'h66);

    // continuous ones realign every eight bits
    w0 = wrCount;
    sendSeq(0, 1, "R7"); sendOnes(24, "R7");
    sendSeq(8'b00000000, 8, "R7");
    check(wrCount == w0 + 1 && lastWr == 8'h00, "R7", "writes after realign",
          wrCount - w0, 1);

    // sync loss watchdog
    i0 = irqCount;
    for (int i = 0; i < 80; i++) sendBit(1, (i % 2) == 0, "R8");
    check(irqCount == i0 + 2, "R8", "interrupts in 80 bits", irqCount - i0, 2);
    check(bomMode == 1, "R8", "mode kept after interrupt", bomMode, 1);

    // flag returns to HDLC
    sendSeq(8'b01111110, 8, "R4");
    check(bomMode == 0, "R4", "mode after flag", bomMode, 0);

    // flag ignored without HDLC receiver
    hdlcEn = 0;
    sendSeq(0, 1, "R4"); sendOnes(8, "R4");
    sendSeq(8'b01111110, 8, "R4");
    sendSeq(8'b10011110, 8, "R4");
    check(bomMode == 1, "R4", "mode with hdlcEn low", bomMode, 1);

    // flag-valued message byte: stored and exits
    hdlcEn = 1;
    w0 = wrCount;
    sendSeq(0, 1, "R11"); sendOnes(8, "R11");
    sendSeq(8'b01111110, 8, "R11");
    check(wrCount == w0 + 1 && lastWr == 8'h7E, "R11", "flag byte stored", lastWr, 8'h7E);
    check(bomMode == 0, "R11", "mode after flag byte", bomMode, 0);

    // disabling clears the mode
    sendSeq(0, 1, "R2"); sendOnes(8, "R2");
    bomEn = 0;
    sendBit(0, 0, "R2");
    check(bomMode == 0, "R2", "mode after disable", bomMode, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule